// File: doc/BRIEF.md
# Battery Charge LED Bar Driver

This block turns a battery's available-charge count into a five-segment LED bar and a 4-bit gauge value in sixteenths. The full-scale reference is either the learned capacity (relative mode) or the programmed full count (absolute mode). In absolute mode a worn battery lights fewer than five segments. At cold temperatures the shown level is derated, and the stored count is never changed.

To save LED current, the segments are time-multiplexed in two banks at a low duty cycle. The lowest segment blinks when charge is low or the end-of-discharge flag is present. The display can be enabled in three separate ways:
- a push-button timer;
- charge or discharge activity;
- a register override that drives the segments directly.

All timing comes from parameterized prescalers on the one system clock.

Top module: `led_gauge_drv`

## Requirements
- R1: The reference is `lmd` when `abs_mode`=0 and `pfc` when `abs_mode`=1. Segment k+1 (seg_n bit k, k=0..4) is lit when 5×scaled ≥ k×reference. Segment 1 is therefore lit at any level unless it is blinking.
- R2: Segments 1, 3 and 5 (bits 0, 2, 4) form bank A and may light only during the first MUX_ON = MUX_PERIOD×3/10 cycles of each MUX_PERIOD. Segments 2 and 4 (bits 1, 3) form bank B and may light only during MUX_ON cycles starting at MUX_PERIOD/2. The two banks are never lit in the same cycle.
- R3: The low condition is `edv`=1 or 10×nac < reference. While it holds, segment 1 lights only during alternate BLINK_HALF-cycle phases.
- R4: Entering the low code of `disp_ctl` (01) starts a PUSH_CYC-cycle timer, and the display is on while the timer runs.
- R5: The high code of `disp_ctl` (1x) turns every segment off and cancels a running push timer.
- R6: With `disp_ctl` floating (00), the display is on only while `chg_fast` or `dsg_fast` is 1.
- R7: Temperature code c stands for 10 °C bands, with code 4 = 0..10 °C. Codes 0–1 scale nac by 0.5 and codes 2–3 scale it by 0.75. Code 5 and above scales by 1.0.
- R8: Hysteresis uses a cold state, set by a code ≤ 3 and cleared by a code ≥ 5. Code 4 scales by 0.75 while the cold state is set and by 1.0 otherwise.
- R9: With `ovr_en`=1, seg_n equals ~ovr_seg (bit i drives segment i+1). This holds regardless of mode, mux phase and display control. Clearing `ovr_en` restores normal drive.
- R10: `gauge` = min(15, floor(16×scaled/reference)).
- R11: During reset, seg_n=5'h1F, gauge=0, the cold state is clear and the push timer is idle.
- R12: Both outputs are registered and reflect the inputs one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nac | input | CW | Available-charge count |
| lmd | input | CW | Learned full reference |
| pfc | input | CW | Programmed full reference |
| abs_mode | input | 1 | 1 selects the programmed reference |
| temp_code | input | 4 | Temperature band code |
| edv | input | 1 | End-of-discharge flag |
| disp_ctl | input | 2 | Display control: 00 floating, 01 low, 1x high |
| chg_fast | input | 1 | Charge activity above display threshold |
| dsg_fast | input | 1 | Discharge activity above display threshold |
| ovr_en | input | 1 | Segment override enable |
| ovr_seg | input | 5 | Override segment pattern |
| seg_n | output | 5 | Active-low segment drives |
| gauge | output | 4 | Level in sixteenths |

## Verification
The bench builds the block with CW=8, MUX_PERIOD=20, BLINK_HALF=60 and PUSH_CYC=200. With these values a whole multiplex period takes 20 cycles, so each segment's on-time can be counted exactly over one window. A 240-cycle window spans two full blink periods, giving exact lit counts with and without blinking. The push timer's expiry falls within a few hundred cycles. An 8-bit charge width keeps the hand-computed thresholds, including the 59/60 segment boundary and overfull charge, small enough to tabulate.

// File: rtl/led_gauge_drv.sv
module led_gauge_drv #(
  parameter int CW         = 16,
  parameter int MUX_PERIOD = 3125,
  parameter int BLINK_HALF = 125000,
  parameter int PUSH_CYC   = 4000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] nac,
  input  logic [CW-1:0] lmd,
  input  logic [CW-1:0] pfc,
  input  logic          abs_mode,
  input  logic [3:0]    temp_code,
  input  logic          edv,
  input  logic [1:0]    disp_ctl,
  input  logic          chg_fast,
  input  logic          dsg_fast,
  input  logic          ovr_en,
  input  logic [4:0]    ovr_seg,
  output logic [4:0]    seg_n,
  output logic [3:0]    gauge
);

  localparam int W        = CW + 7;
  localparam int MUX_HALF = MUX_PERIOD / 2;
  localparam int MUX_ON   = (MUX_PERIOD * 3) / 10;
  localparam int MW       = $clog2(MUX_PERIOD);
  localparam int BW       = $clog2(BLINK_HALF);
  localparam int PW       = $clog2(PUSH_CYC + 1);

  logic [MW-1:0] mux_cnt;
  logic [BW-1:0] blink_cnt;
  logic          blink_on;
  logic [PW-1:0] push_cnt;
  logic          prev_low;
  logic          cold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_cnt   <= '0;
      blink_cnt <= '0;
      blink_on  <= 1'b1;
    end else begin
      mux_cnt <= (mux_cnt == MW'(MUX_PERIOD - 1)) ? '0 : mux_cnt + 1'b1;
      if (blink_cnt == BW'(BLINK_HALF - 1)) begin
        blink_cnt <= '0;
        blink_on  <= ~blink_on;
      end else begin
        blink_cnt <= blink_cnt + 1'b1;
      end
    end
  end

  wire is_low   = (disp_ctl == 2'b01);
  wire is_high  = disp_ctl[1];
  wire is_float = (disp_ctl == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_cnt <= '0;
      prev_low <= 1'b0;
      cold     <= 1'b0;
    end else begin
      prev_low <= is_low;
      if (is_high)                   push_cnt <= '0;
      else if (is_low && !prev_low)  push_cnt <= PW'(PUSH_CYC);
      else if (push_cnt != '0)       push_cnt <= push_cnt - 1'b1;
      if (temp_code <= 4'd3)         cold <= 1'b1;
      else if (temp_code >= 4'd5)    cold <= 1'b0;
    end
  end

  wire [W-1:0] nac_w = W'(nac);
  wire [W-1:0] ref_w = abs_mode ? W'(pfc) : W'(lmd);

  logic [W-1:0] sc4;
  always_comb begin
    if (temp_code <= 4'd1)
      sc4 = nac_w << 1;
    else if (temp_code <= 4'd3 || (temp_code == 4'd4 && cold))
      sc4 = (nac_w << 1) + nac_w;
    else
      sc4 = nac_w << 2;
  end

  logic [4:0] lvl;
  for (genvar k = 0; k < 5; k++) begin : g_lvl
    assign lvl[k] = (W'(5) * sc4) >= (ref_w * W'(4 * k));
  end

  logic [3:0] g_next;
  always_comb begin
    g_next = '0;
    for (int j = 1; j < 16; j++)
      if ((sc4 << 4) >= ref_w * W'(4 * j)) g_next = g_next + 4'd1;
  end

  wire low_chg = edv || ((nac_w * W'(10)) < ref_w);
  wire bank_a  = mux_cnt < MW'(MUX_ON);
  wire bank_b  = (mux_cnt >= MW'(MUX_HALF)) && (mux_cnt < MW'(MUX_HALF + MUX_ON));
  wire disp_on = !is_high && ((push_cnt != '0) || (is_float && (chg_fast || dsg_fast)));

  wire [4:0] mask = {bank_a, bank_b, bank_a, bank_b, bank_a};
  wire [4:0] show = lvl & {4'hF, (!low_chg || blink_on)} & mask & {5{disp_on}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_n <= 5'h1F;
      gauge <= '0;
    end else begin
      seg_n <= ovr_en ? ~ovr_seg : ~show;
      gauge <= g_next;
    end
  end

endmodule

// File: rtl/led_gauge_drv_chk.sv
module led_gauge_drv_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] disp_ctl,
  input logic       ovr_en,
  input logic [4:0] ovr_seg,
  input logic [4:0] seg_n,
  input logic [3:0] gauge
);

  a_r2_banks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ovr_en) |-> !(((~seg_n & 5'b10101) != 5'b0) && ((~seg_n & 5'b01010) != 5'b0)));

  a_r9_override: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_en |=> (seg_n == ~$past(ovr_seg)));

  a_r5_high_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_ctl[1] && !ovr_en) |=> (seg_n == 5'h1F));

  a_r1_top_seg_gauge: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ovr_en) && !seg_n[4]) |-> (gauge >= 4'd12));

  a_r10_seg4_gauge: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ovr_en) && !seg_n[3]) |-> (gauge >= 4'd9));

endmodule

bind led_gauge_drv led_gauge_drv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .disp_ctl(disp_ctl), .ovr_en(ovr_en),
  .ovr_seg(ovr_seg), .seg_n(seg_n), .gauge(gauge)
);

// File: tb/led_gauge_drv_bench.sv
module led_gauge_drv_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] nac = 8'd0, lmd = 8'd100, pfc = 8'd200;
  logic       abs_mode = 1'b0;
  logic [3:0] temp_code = 4'd6;
  logic       edv = 1'b0;
  logic [1:0] disp_ctl = 2'b00;
  logic       chg_fast = 1'b1, dsg_fast = 1'b0;
  logic       ovr_en = 1'b0;
  logic [4:0] ovr_seg = 5'b0;
  logic [4:0] seg_n;
  logic [3:0] gauge;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  led_gauge_drv #(.CW(8), .MUX_PERIOD(20), .BLINK_HALF(60), .PUSH_CYC(200)) u_led_gauge_drv (
    .clk(clk), .rst_n(rst_n), .nac(nac), .lmd(lmd), .pfc(pfc), .abs_mode(abs_mode),
    .temp_code(temp_code), .edv(edv), .disp_ctl(disp_ctl), .chg_fast(chg_fast),
    .dsg_fast(dsg_fast), .ovr_en(ovr_en), .ovr_seg(ovr_seg), .seg_n(seg_n), .gauge(gauge)
  );

  typedef struct packed {
    logic       am;
    logic [3:0] tc;
    logic [7:0] n;
    logic [4:0] es;
    logic [3:0] eg;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b0, 4'd6, 8'd100, 5'h1F, 4'd15},
    '{1'b0, 4'd6, 8'd50,  5'h07, 4'd8},
    '{1'b0, 4'd6, 8'd59,  5'h07, 4'd9},
    '{1'b0, 4'd6, 8'd60,  5'h0F, 4'd9},
    '{1'b1, 4'd6, 8'd100, 5'h07, 4'd8},
    '{1'b1, 4'd6, 8'd200, 5'h1F, 4'd15},
    '{1'b0, 4'd2, 8'd80,  5'h0F, 4'd9},
    '{1'b0, 4'd1, 8'd80,  5'h07, 4'd6},
    '{1'b0, 4'd6, 8'd80,  5'h1F, 4'd12},
    '{1'b0, 4'd6, 8'd20,  5'h03, 4'd3},
    '{1'b0, 4'd6, 8'd250, 5'h1F, 4'd15},
    '{1'b1, 4'd6, 8'd40,  5'h03, 4'd3}
  };

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic observe(input int n, output logic [4:0] uni, output int c1, output int both);
    uni = '0; c1 = 0; both = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      uni = uni | ~seg_n;
      if (!seg_n[0]) c1++;
      if (((~seg_n & 5'b10101) != 0) && ((~seg_n & 5'b01010) != 0)) both++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [4:0] u;
    int c, b;
    nac = 8'd100;
    cyc(4);
    check("R11 reset seg_n", seg_n == 5'h1F, seg_n, 5'h1F);
    check("R11 reset gauge", gauge == 4'd0, gauge, 0);
    rst_n = 1'b1;
    cyc(2);

    for (int i = 0; i < 12; i++) begin
      abs_mode = VEC[i].am; temp_code = VEC[i].tc; nac = VEC[i].n;
      cyc(3);
      check($sformatf("R10 R7 gauge vec %0d", i), gauge == VEC[i].eg, gauge, VEC[i].eg);
      observe(20, u, c, b);
      check($sformatf("R1 R7 segments vec %0d", i), u == VEC[i].es, u, VEC[i].es);
    end

    abs_mode = 0; temp_code = 6; nac = 100;
    cyc(3);
    observe(20, u, c, b);
    check("R2 seg1 on-cycles per period", c == 6, c, 6);
    check("R2 banks never together", b == 0, b, 0);

    temp_code = 3; nac = 80; cyc(3);
    check("R8 cold code 3", gauge == 9, gauge, 9);
    temp_code = 4; cyc(3);
    check("R8 code 4 holds cold", gauge == 9, gauge, 9);
    temp_code = 5; cyc(3);
    check("R8 code 5 leaves cold", gauge == 12, gauge, 12);
    temp_code = 4; cyc(3);
    check("R8 code 4 stays warm", gauge == 12, gauge, 12);
    temp_code = 6;

    nac = 9; cyc(3);
    observe(240, u, c, b);
    check("R3 blink on low charge", c == 36, c, 36);
    nac = 80; edv = 1; cyc(3);
    observe(240, u, c, b);
    check("R3 blink on edv", c == 36, c, 36);
    edv = 0; cyc(3);
    observe(240, u, c, b);
    check("R3 steady when not low", c == 72, c, 72);
    abs_mode = 1; nac = 15; cyc(3);
    observe(240, u, c, b);
    check("R3 low vs programmed reference", c == 36, c, 36);
    abs_mode = 0; cyc(3);
    observe(240, u, c, b);
    check("R3 not low vs learned reference", c == 72, c, 72);

    nac = 100; chg_fast = 0; cyc(3);
    observe(20, u, c, b);
    check("R6 float idle dark", u == 0, u, 0);
    dsg_fast = 1; cyc(3);
    observe(20, u, c, b);
    check("R6 float discharge on", u == 5'h1F, u, 5'h1F);
    chg_fast = 1; disp_ctl = 2'b10; cyc(3);
    observe(40, u, c, b);
    check("R5 high forces dark", u == 0, u, 0);
    chg_fast = 0; dsg_fast = 0; disp_ctl = 2'b00; cyc(3);

    disp_ctl = 2'b01; cyc(1);
    disp_ctl = 2'b00; cyc(9);
    observe(20, u, c, b);
    check("R4 push timer lights", u == 5'h1F, u, 5'h1F);
    cyc(185);
    observe(40, u, c, b);
    check("R4 push timer expires", u == 0, u, 0);
    disp_ctl = 2'b01; cyc(1);
    disp_ctl = 2'b00; cyc(20);
    disp_ctl = 2'b10; cyc(2);
    disp_ctl = 2'b00; cyc(3);
    observe(40, u, c, b);
    check("R5 high cancels push timer", u == 0, u, 0);

    ovr_en = 1; ovr_seg = 5'b10110; disp_ctl = 2'b10; cyc(2);
    observe(20, u, c, b);
    check("R9 override pattern", u == 5'b10110, u, 5'b10110);
    check("R9 override steady", c == 0, c, 0);
    ovr_en = 0; disp_ctl = 2'b00; chg_fast = 1; cyc(3);
    observe(20, u, c, b);
    check("R9 override released", u == 5'h1F, u, 5'h1F);

    nac = 20; @(negedge clk); nac = 100;
    check("R12 gauge one cycle latency", gauge == 3, gauge, 3);
    @(negedge clk);
    check("R12 gauge updated", gauge == 15, gauge, 15);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule